// File: doc/BRIEF.md
# Prescaled Up/Down Alarm Timer

This block is a general-purpose time base. Software sets it up through a small register port. A 32-bit control word selects one of two tick-enable inputs: a bus-rate tick or a crystal-rate tick. A 16-bit prescaler divides the selected tick. Each divided tick moves a wide counter one step up or down.

An alarm register holds a compare value. While the alarm is armed and the counter equals that value, the block emits a one-cycle alarm pulse and disarms itself in hardware. If auto-reload is enabled, the counter is also reloaded from a load register on that same edge.

Software can also copy the load register into the counter at any time with a strobe write. A second write-only strobe clears the prescaler's internal divide count.

The register port is write/read with one-cycle read latency. All state sits in one clock domain, and both tick sources are plain enables sampled in that domain.

Top module: `tick_alarm_timer`

## Requirements
- R1: After synchronous reset the control word reads 0x6000_2000, the counter reads 0 and `alarm_o` is 0.
- R2: The control word (address 0) places the fields as follows: bit 31 run, bit 30 count-up, bit 29 auto-reload, bits 28:13 divide value, bit 12 prescaler-clear strobe, bit 10 alarm arm, bit 9 source select. All other bits read 0.
- R3: When bit 9 is 1 only `tick_xtal_i` advances the prescaler, and when it is 0 only `tick_bus_i` does. The unselected input has no effect on the count.
- R4: With divide value N the counter steps once every N selected ticks. N = 1 steps on every tick, and N = 0 behaves as divide-by-2.
- R5: Writing the control word with bit 12 set restarts the divide count from zero. Bit 12 always reads back 0.
- R6: Each divided tick adds 1 when bit 30 is 1 and subtracts 1 when it is 0. The counter wraps modulo 2^CNT_W in both directions.
- R7: While bit 31 is 0 the counter and the prescaler hold their values, whatever ticks arrive.
- R8: Any write to address 5 copies the load register (low word at address 3, high bits at address 4) into the counter on that edge. This takes priority over a tick.
- R9: While armed, a counter value equal to the alarm register (low word at address 1, high bits at address 2) drives `alarm_o` high in the next cycle, for exactly one cycle.
- R10: The arm bit is cleared on the same edge that raises `alarm_o`. No further alarm occurs until software re-arms it, even if the counter meets the compare value again.
- R11: With auto-reload set, the alarm edge loads the counter from the load register. With it clear, the counter keeps its value and then continues counting past the compare value.
- R12: `rd_data` returns the register selected by `rd_addr` one cycle later. Address 6 holds counter bits 31:0 and address 7 holds the counter bits above 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| tick_bus_i | input | 1 | Bus-rate tick enable |
| tick_xtal_i | input | 1 | Crystal-rate tick enable |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
The bench builds the timer with the default 54-bit counter. Loading an all-ones value through the load register brings both wrap directions within a few ticks, and it also exercises the split of the counter across two read words. Divide values of 0, 1 and 3 are used so that the divide-by-2 special case and the restart strobe can be observed in small tick counts. Alarms are exercised both with and without auto-reload, including a later pass over the compare value after the block has disarmed itself.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W     = 32;
  localparam int PSC_W      = 16;
  localparam int BIT_SRC    = 9;
  localparam int BIT_ARM    = 10;
  localparam int BIT_PCLR   = 12;
  localparam int BIT_PSC_LO = 13;
  localparam int BIT_RELOAD = 29;
  localparam int BIT_UP     = 30;
  localparam int BIT_RUN    = 31;

  typedef enum logic [2:0] {
    A_CFG    = 3'd0,
    A_ALM_LO = 3'd1,
    A_ALM_HI = 3'd2,
    A_LD_LO  = 3'd3,
    A_LD_HI  = 3'd4,
    A_LD_GO  = 3'd5,
    A_CNT_LO = 3'd6,
    A_CNT_HI = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic             run;
    logic             up;
    logic             reload;
    logic [PSC_W-1:0] psc;
    logic             arm;
    logic             src_xtal;
  } cfg_t;

  function automatic cfg_t cfg_reset();
    cfg_t c;
    c.run      = 1'b0;
    c.up       = 1'b1;
    c.reload   = 1'b1;
    c.psc      = PSC_W'(1);
    c.arm      = 1'b0;
    c.src_xtal = 1'b0;
    return c;
  endfunction

  function automatic cfg_t cfg_from_word(logic [WORD_W-1:0] w);
    cfg_t c;
    c.run      = w[BIT_RUN];
    c.up       = w[BIT_UP];
    c.reload   = w[BIT_RELOAD];
    c.psc      = w[BIT_PSC_LO +: PSC_W];
    c.arm      = w[BIT_ARM];
    c.src_xtal = w[BIT_SRC];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(cfg_t c);
    logic [WORD_W-1:0] w;
    w                      = '0;
    w[BIT_RUN]             = c.run;
    w[BIT_UP]              = c.up;
    w[BIT_RELOAD]          = c.reload;
    w[BIT_PSC_LO +: PSC_W] = c.psc;
    w[BIT_ARM]             = c.arm;
    w[BIT_SRC]             = c.src_xtal;
    return w;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 54
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 arm_clr,
  output cfg_t                 cfg,
  output logic [CNT_W-1:0]     alarm_val,
  output logic [CNT_W-1:0]     load_val,
  output logic                 load_go,
  output logic                 psc_clr
);
  localparam int HI_W = CNT_W - WORD_W;

  cfg_t             cfg_q;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] load_q;

  assign load_go = wr_en && (wr_addr == A_LD_GO);
  assign psc_clr = wr_en && (wr_addr == A_CFG) && wr_data[BIT_PCLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= cfg_reset();
      alarm_q <= '0;
      load_q  <= '0;
    end else begin
      if (wr_en) begin
        case (reg_addr_e'(wr_addr))
          A_CFG:    cfg_q                    <= cfg_from_word(wr_data);
          A_ALM_LO: alarm_q[WORD_W-1:0]      <= wr_data;
          A_ALM_HI: alarm_q[CNT_W-1:WORD_W]  <= wr_data[HI_W-1:0];
          A_LD_LO:  load_q[WORD_W-1:0]       <= wr_data;
          A_LD_HI:  load_q[CNT_W-1:WORD_W]   <= wr_data[HI_W-1:0];
          default:  ;
        endcase
      end
      // hardware disarm wins over a software write in the same cycle
      if (arm_clr) cfg_q.arm <= 1'b0;
    end
  end

  assign cfg       = cfg_q;
  assign alarm_val = alarm_q;
  assign load_val  = load_q;

  assert_disarm_R10: assert property (@(posedge clk) disable iff (rst)
    arm_clr |=> !cfg_q.arm);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             src_tick,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] last;
  logic             wrap;

  // divide value 0 is treated as 2, so the terminal count is 1
  assign last = (psc == '0) ? PSC_W'(1) : psc - PSC_W'(1);
  assign wrap = (div_q >= last);
  assign tick = run && src_tick && wrap;

  always_ff @(posedge clk) begin
    if (rst || clr)
      div_q <= '0;
    else if (run && src_tick)
      div_q <= wrap ? '0 : div_q + PSC_W'(1);
  end

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (div_q == '0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(div_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 54
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up,
  input  logic             load_go,
  input  logic [CNT_W-1:0] load_val,
  input  logic             arm,
  input  logic             reload,
  input  logic [CNT_W-1:0] alarm_val,
  output logic [CNT_W-1:0] count,
  output logic             hit,
  output logic             alarm_o
);
  logic [CNT_W-1:0] count_q;
  logic             alarm_q;

  assign hit = arm && (count_q == alarm_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= hit;
      if (load_go || (hit && reload))
        count_q <= load_val;
      else if (step)
        count_q <= up ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
    end
  end

  assign count   = count_q;
  assign alarm_o = alarm_q;

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    alarm_q |=> !alarm_q);
  assert_reload_R11: assert property (@(posedge clk) disable iff (rst)
    (hit && reload && !load_go) |=> (count_q == $past(load_val)));
  assert_load_R8: assert property (@(posedge clk) disable iff (rst)
    load_go |=> (count_q == $past(load_val)));
  assert_up_R6: assert property (@(posedge clk) disable iff (rst)
    (step && up && !hit && !load_go) |=> (count_q == $past(count_q) + CNT_W'(1)));
  assert_down_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !up && !hit && !load_go) |=> (count_q == $past(count_q) - CNT_W'(1)));
  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!step && !hit && !load_go) |=> $stable(count_q));
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 54   // must lie in 33..64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        tick_bus_i,
  input  logic        tick_xtal_i,
  output logic        alarm_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] alarm_val;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic             load_go;
  logic             psc_clr;
  logic             src_tick;
  logic             step;
  logic             hit;
  logic [31:0]      rd_q;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .arm_clr   (hit),
    .cfg       (cfg),
    .alarm_val (alarm_val),
    .load_val  (load_val),
    .load_go   (load_go),
    .psc_clr   (psc_clr)
  );

  assign src_tick = cfg.src_xtal ? tick_xtal_i : tick_bus_i;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk      (clk),
    .rst      (rst),
    .clr      (psc_clr),
    .run      (cfg.run),
    .src_tick (src_tick),
    .psc      (cfg.psc),
    .tick     (step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .up        (cfg.up),
    .load_go   (load_go),
    .load_val  (load_val),
    .arm       (cfg.arm),
    .reload    (cfg.reload),
    .alarm_val (alarm_val),
    .count     (count),
    .hit       (hit),
    .alarm_o   (alarm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (reg_addr_e'(rd_addr))
        A_CFG:    rd_q <= cfg_to_word(cfg);
        A_ALM_LO: rd_q <= alarm_val[31:0];
        A_ALM_HI: rd_q <= 32'(alarm_val >> 32);
        A_LD_LO:  rd_q <= load_val[31:0];
        A_LD_HI:  rd_q <= 32'(load_val >> 32);
        A_CNT_LO: rd_q <= count[31:0];
        A_CNT_HI: rd_q <= 32'(count >> 32);
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;

  assert_alarm_disarmed_R10: assert property (@(posedge clk) disable iff (rst)
    alarm_o |-> !cfg.arm);
  assert_strobe_bit_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == A_CFG) |-> !rd_q[BIT_PCLR]);
endmodule

// File: tb/tb_tick_alarm_timer.sv
module tb_tick_alarm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 54;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick_bus_i = 1'b0;
  logic        tick_xtal_i = 1'b0;
  logic        alarm_o;

  int checks = 0;
  int errors = 0;

  tick_alarm_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_bus_i(tick_bus_i),
    .tick_xtal_i(tick_xtal_i), .alarm_o(alarm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] cw(input logic run, input logic up, input logic rel,
                                      input logic [15:0] psc, input logic clr,
                                      input logic arm, input logic src);
    return {run, up, rel, psc, clr, 1'b0, arm, src, 9'b0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(3'd6, lo);
    rd(3'd7, hi);
    v = (64'(hi) << 32) | 64'(lo);
  endtask

  task automatic ticks(input bit xtal, input int n);
    if (xtal) tick_xtal_i = 1'b1; else tick_bus_i = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_xtal_i = 1'b0; tick_bus_i = 1'b0;
  endtask

  task automatic load_count(input logic [63:0] v);
    wr(3'd3, v[31:0]);
    wr(3'd4, v[63:32]);
    wr(3'd5, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] w; logic [63:0] c;
    chk("R1 alarm_o", 64'(alarm_o), 64'd0);
    rd(3'd0, w);
    chk("R1 cfg", 64'(w), 64'h6000_2000);
    rd_cnt(c);
    chk("R1 count", c, 64'd0);
  endtask

  task automatic t_up_div1();
    logic [63:0] c;
    wr(3'd0, cw(1, 1, 0, 16'd1, 0, 0, 0));
    ticks(0, 10);
    rd_cnt(c);
    chk("R4 R6 up div1 (R2 R12)", c, 64'd10);
  endtask

  task automatic t_src();
    logic [63:0] c;
    ticks(1, 7);
    rd_cnt(c);
    chk("R3 xtal ignored", c, 64'd10);
    wr(3'd0, cw(1, 1, 0, 16'd1, 0, 0, 1));
    ticks(1, 4);
    rd_cnt(c);
    chk("R3 xtal selected", c, 64'd14);
    ticks(0, 5);
    rd_cnt(c);
    chk("R3 bus ignored", c, 64'd14);
  endtask

  task automatic t_div();
    logic [63:0] c;
    wr(3'd0, cw(1, 1, 0, 16'd3, 1, 0, 0));
    ticks(0, 9);
    rd_cnt(c);
    chk("R4 div3", c, 64'd17);
    wr(3'd0, cw(1, 1, 0, 16'd0, 1, 0, 0));
    ticks(0, 6);
    rd_cnt(c);
    chk("R4 div0 as 2", c, 64'd20);
  endtask

  task automatic t_clr();
    logic [63:0] c; logic [31:0] w;
    wr(3'd0, cw(1, 1, 0, 16'd3, 1, 0, 0));
    ticks(0, 2);
    wr(3'd0, cw(1, 1, 0, 16'd3, 1, 0, 0));
    ticks(0, 1);
    rd_cnt(c);
    chk("R5 restart holds step", c, 64'd20);
    ticks(0, 2);
    rd_cnt(c);
    chk("R5 step after restart", c, 64'd21);
    rd(3'd0, w);
    chk("R5 strobe reads 0", 64'(w), 64'(cw(1, 1, 0, 16'd3, 0, 0, 0)));
  endtask

  task automatic t_down_load();
    logic [63:0] c;
    wr(3'd0, cw(1, 1, 0, 16'd1, 1, 0, 0));
    wr(3'd3, 32'd100);
    wr(3'd4, 32'd0);
    tick_bus_i = 1'b1;
    wr(3'd5, 32'd0);
    tick_bus_i = 1'b0;
    rd_cnt(c);
    chk("R8 load over tick", c, 64'd100);
    wr(3'd0, cw(1, 0, 0, 16'd1, 0, 0, 0));
    ticks(0, 5);
    rd_cnt(c);
    chk("R6 down", c, 64'd95);
  endtask

  task automatic t_freeze();
    logic [63:0] c;
    wr(3'd0, cw(0, 0, 0, 16'd1, 0, 0, 0));
    ticks(0, 6);
    ticks(1, 3);
    rd_cnt(c);
    chk("R7 frozen", c, 64'd95);
  endtask

  task automatic t_wrap();
    logic [63:0] c; logic [63:0] ones;
    ones = (64'd1 << CW) - 64'd1;
    load_count(ones);
    wr(3'd0, cw(1, 1, 0, 16'd1, 0, 0, 0));
    ticks(0, 1);
    rd_cnt(c);
    chk("R6 wrap up", c, 64'd0);
    wr(3'd0, cw(1, 0, 0, 16'd1, 0, 0, 0));
    ticks(0, 1);
    rd_cnt(c);
    chk("R6 R12 wrap down", c, ones);
  endtask

  task automatic t_alarm_once();
    logic [63:0] c; logic [31:0] w;
    load_count(64'd0);
    wr(3'd1, 32'd5);
    wr(3'd2, 32'd0);
    wr(3'd0, cw(1, 1, 0, 16'd1, 0, 1, 0));
    ticks(0, 5);
    chk("R9 no pulse before edge", 64'(alarm_o), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 pulse high", 64'(alarm_o), 64'd1);
    @(posedge clk); @(negedge clk);
    chk("R9 pulse one cycle", 64'(alarm_o), 64'd0);
    rd(3'd0, w);
    chk("R10 arm cleared", 64'(w[10]), 64'd0);
    rd_cnt(c);
    chk("R11 no reload", c, 64'd5);
    ticks(0, 3);
    rd_cnt(c);
    chk("R11 counts past", c, 64'd8);
    load_count(64'd0);
    ticks(0, 5);
    @(posedge clk); @(negedge clk);
    chk("R10 no refire", 64'(alarm_o), 64'd0);
  endtask

  task automatic t_alarm_reload();
    logic [63:0] c;
    wr(3'd0, cw(1, 1, 1, 16'd1, 0, 0, 0));
    load_count(64'd0);
    wr(3'd1, 32'd4);
    wr(3'd3, 32'd1000);
    wr(3'd0, cw(1, 1, 1, 16'd1, 0, 1, 0));
    ticks(0, 4);
    @(posedge clk); @(negedge clk);
    chk("R9 reload pulse", 64'(alarm_o), 64'd1);
    rd_cnt(c);
    chk("R11 reloaded", c, 64'd1000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_up_div1();
    t_src();
    t_div();
    t_clr();
    t_down_load();
    t_freeze();
    t_wrap();
    t_alarm_once();
    t_alarm_reload();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule